// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block is the home side of a directory-based coherence scheme for distributed shared memory. For every memory block it holds a local copy of the data, a coherence state and a vector with one presence bit per processor. Caches send it read misses, write misses and write-backs. It answers with point-to-point messages: invalidations to sharers, fetch or fetch-and-invalidate requests to an owner, and a data reply to the requester. No message is broadcast.

Requests arrive on a valid/ready channel, and one request is handled at a time. A block can be Uncached (no cache holds it, and the presence vector is empty), Shared (one or more readers hold it, and memory is current) or Exclusive (a single owner holds it, and memory is stale). A miss that finds the block Exclusive makes the controller ask the owner for the block. It then waits on a separate response input, writes the returned value into local memory and replies from there. While it waits, `req_ready` stays low for every block.

FSM states: `ST_IDLE` (ready for a request), `ST_LOOKUP` (read the entry and decide), `ST_INV` (issue one invalidation per cycle), `ST_FETCH` (send fetch or fetch/invalidate to the owner), `ST_WAIT` (hold until owner data arrives) and `ST_REPLY` (send the data reply).

FSM transitions: IDLE→LOOKUP on an accepted request. LOOKUP→REPLY for a miss to an Uncached or Shared block. LOOKUP→INV for a write miss to a Shared block with other sharers. LOOKUP→FETCH for a miss to an Exclusive block. LOOKUP→IDLE for write-backs and unused codes. INV→REPLY after the last invalidation. FETCH→WAIT. WAIT→REPLY on `rsp_valid`. REPLY→IDLE.

Top module: `dir_home`

## Requirements
- R1: After reset, every block is Uncached with an empty presence vector and zero data. `req_ready` is 1 and `msg_valid` is 0.
- R2: Request kind codes are 0 = read miss, 1 = write miss, 2 = write-back. A read miss to an Uncached block sends one reply (message kind 4) with the memory data to the requester. The block becomes Shared with only the requester present.
- R3: A write miss to an Uncached block sends one reply (kind 4) with the memory data. The block becomes Exclusive with the requester as sole owner.
- R4: A read miss to a Shared block sends one reply (kind 4) with the memory data and adds the requester to the presence vector.
- R5: A write miss to a Shared block first sends one invalidation (kind 1) per cycle to each present processor other than the requester, in ascending processor index. It then sends a reply (kind 4). The block becomes Exclusive with the requester as owner.
- R6: A read miss to an Exclusive block sends a fetch (kind 2) to the owner and waits for `rsp_valid`. It stores `rsp_data` in memory and replies (kind 4) with it. The block becomes Shared, with both the old owner and the requester present.
- R7: A write miss to an Exclusive block sends a fetch/invalidate (kind 3) to the owner and waits for `rsp_valid`. It stores `rsp_data` in memory and replies (kind 4) with it. The block stays Exclusive with the requester as the only owner.
- R8: A write-back to an Exclusive block writes `req_data` to memory and leaves the block Uncached and empty. It sends no message.
- R9: A write-back to a block that is not Exclusive, and any request with kind code 3, changes neither state nor memory and sends no message.
- R10: From the fetch message until the reply, `req_ready` stays 0. Every message carries the request's block address in `msg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_pid | input | $clog2(NPROC) | Requesting processor |
| req_addr | input | $clog2(NBLK) | Block index |
| req_data | input | DW | Write-back data |
| rsp_valid | input | 1 | Owner data returned after a fetch |
| rsp_data | input | DW | Owner's block value |
| msg_valid | output | 1 | Outgoing message valid this cycle |
| msg_kind | output | 3 | 1 invalidate, 2 fetch, 3 fetch/invalidate, 4 reply |
| msg_dest | output | $clog2(NPROC) | Destination processor |
| msg_addr | output | $clog2(NBLK) | Block index of the message |
| msg_data | output | DW | Reply data (0 for other kinds) |

## Verification
The assertions check structural invariants on every cycle. Any Exclusive entry has exactly one present bit, Shared entries are never empty and Uncached entries always are. Invalidations never target the requester and rise strictly in destination. A fetch always drops `req_ready`, and a reply always restores it. Only the bench scenarios can show the data path and the protocol outcome: that fetched owner data lands in memory and is the value replied, that presence sets evolve correctly across sequences, and that ignored write-backs leave memory untouched. The bench compares every message against a reference model of the directory while the owner's response arrives after a varying delay.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        BLK_UNC = 2'd0,
        BLK_SHR = 2'd1,
        BLK_EXC = 2'd2
    } blk_state_e;

    typedef enum logic [1:0] {
        REQ_RD  = 2'd0,
        REQ_WR  = 2'd1,
        REQ_WB  = 2'd2,
        REQ_NOP = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        MSG_NONE      = 3'd0,
        MSG_INV       = 3'd1,
        MSG_FETCH     = 3'd2,
        MSG_FETCH_INV = 3'd3,
        MSG_REPLY     = 3'd4
    } msg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_INV    = 3'd2,
        ST_FETCH  = 3'd3,
        ST_WAIT   = 3'd4,
        ST_REPLY  = 3'd5
    } ctl_state_e;

endpackage

// File: rtl/dir_pick.sv
// Lowest-index set bit finder.
module dir_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dir_store.sv
// Per-block directory entries and block data, one shared address.
module dir_store
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             dir_we,
    input  blk_state_e       dir_st_in,
    input  logic [NPROC-1:0] dir_sh_in,
    input  logic             mem_we,
    input  logic [DW-1:0]    mem_din,
    output blk_state_e       st_out,
    output logic [NPROC-1:0] sh_out,
    output logic [DW-1:0]    mem_dout
);
    blk_state_e       st_q  [NBLK];
    logic [NPROC-1:0] sh_q  [NBLK];
    logic [DW-1:0]    mem_q [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[b]  <= BLK_UNC;
                sh_q[b]  <= '0;
                mem_q[b] <= '0;
            end else begin
                if (dir_we && addr == AW'(b)) begin
                    st_q[b] <= dir_st_in;
                    sh_q[b] <= dir_sh_in;
                end
                if (mem_we && addr == AW'(b)) begin
                    mem_q[b] <= mem_din;
                end
            end
        end
    end

    always_comb begin
        st_out   = st_q[addr];
        sh_out   = sh_q[addr];
        mem_dout = mem_q[addr];
    end
endmodule

// File: rtl/dir_home.sv
// Home-node coherence directory controller.
module dir_home
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [PW-1:0] req_pid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic          msg_valid,
    output logic [2:0]    msg_kind,
    output logic [PW-1:0] msg_dest,
    output logic [AW-1:0] msg_addr,
    output logic [DW-1:0] msg_data
);
    ctl_state_e       state_q, state_d;
    req_kind_e        kind_q;
    logic [PW-1:0]    pid_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;
    logic [NPROC-1:0] scan_q, scan_d;
    logic [PW-1:0]    owner_q, owner_d;

    logic             dir_we, mem_we;
    blk_state_e       dir_st_in;
    logic [NPROC-1:0] dir_sh_in;
    logic [DW-1:0]    mem_din;
    blk_state_e       st_rd;
    logic [NPROC-1:0] sh_rd;
    logic [DW-1:0]    mem_rd;

    logic             owner_found, inv_found;
    logic [PW-1:0]    owner_idx, inv_idx;
    logic [NPROC-1:0] pid_oh, inv_oh;

    assign pid_oh = NPROC'(1) << pid_q;
    assign inv_oh = NPROC'(1) << inv_idx;

    dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr_q),
        .dir_we    (dir_we),
        .dir_st_in (dir_st_in),
        .dir_sh_in (dir_sh_in),
        .mem_we    (mem_we),
        .mem_din   (mem_din),
        .st_out    (st_rd),
        .sh_out    (sh_rd),
        .mem_dout  (mem_rd)
    );

    dir_pick #(.N(NPROC)) u_owner (
        .vec   (sh_rd),
        .found (owner_found),
        .idx   (owner_idx)
    );

    dir_pick #(.N(NPROC)) u_inv (
        .vec   (scan_q),
        .found (inv_found),
        .idx   (inv_idx)
    );

    // Next state, directory updates and memory writes
    always_comb begin
        state_d   = state_q;
        scan_d    = scan_q;
        owner_d   = owner_q;
        dir_we    = 1'b0;
        dir_st_in = st_rd;
        dir_sh_in = sh_rd;
        mem_we    = 1'b0;
        mem_din   = data_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                unique case (kind_q)
                    REQ_RD: begin
                        unique case (st_rd)
                            BLK_UNC: begin
                                dir_we = 1'b1; dir_st_in = BLK_SHR; dir_sh_in = pid_oh;
                                state_d = ST_REPLY;
                            end
                            BLK_SHR: begin
                                dir_we = 1'b1; dir_st_in = BLK_SHR; dir_sh_in = sh_rd | pid_oh;
                                state_d = ST_REPLY;
                            end
                            BLK_EXC: begin
                                owner_d = owner_idx;
                                state_d = ST_FETCH;
                            end
                            default: state_d = ST_IDLE;
                        endcase
                    end
                    REQ_WR: begin
                        unique case (st_rd)
                            BLK_UNC: begin
                                dir_we = 1'b1; dir_st_in = BLK_EXC; dir_sh_in = pid_oh;
                                state_d = ST_REPLY;
                            end
                            BLK_SHR: begin
                                scan_d = sh_rd & ~pid_oh;
                                dir_we = 1'b1; dir_st_in = BLK_EXC; dir_sh_in = pid_oh;
                                state_d = (scan_d != '0) ? ST_INV : ST_REPLY;
                            end
                            BLK_EXC: begin
                                owner_d = owner_idx;
                                state_d = ST_FETCH;
                            end
                            default: state_d = ST_IDLE;
                        endcase
                    end
                    REQ_WB: begin
                        if (st_rd == BLK_EXC) begin
                            mem_we = 1'b1; mem_din = data_q;
                            dir_we = 1'b1; dir_st_in = BLK_UNC; dir_sh_in = '0;
                        end
                        state_d = ST_IDLE;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
            ST_INV: begin
                scan_d = scan_q & ~inv_oh;
                if (!inv_found || scan_d == '0) state_d = ST_REPLY;
            end
            ST_FETCH: begin
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    mem_we  = 1'b1;
                    mem_din = rsp_data;
                    dir_we  = 1'b1;
                    if (kind_q == REQ_RD) begin
                        dir_st_in = BLK_SHR; dir_sh_in = sh_rd | pid_oh;
                    end else begin
                        dir_st_in = BLK_EXC; dir_sh_in = pid_oh;
                    end
                    state_d = ST_REPLY;
                end
            end
            ST_REPLY: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= REQ_NOP;
            pid_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            scan_q  <= '0;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            scan_q  <= scan_d;
            owner_q <= owner_d;
            if (state_q == ST_IDLE && req_valid) begin
                kind_q <= req_kind_e'(req_kind);
                pid_q  <= req_pid;
                addr_q <= req_addr;
                data_q <= req_data;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        msg_valid = 1'b0;
        msg_kind  = MSG_NONE;
        msg_dest  = '0;
        msg_addr  = addr_q;
        msg_data  = '0;
        unique case (state_q)
            ST_INV: begin
                msg_valid = inv_found;
                msg_kind  = MSG_INV;
                msg_dest  = inv_idx;
            end
            ST_FETCH: begin
                msg_valid = 1'b1;
                msg_kind  = (kind_q == REQ_WR) ? MSG_FETCH_INV : MSG_FETCH;
                msg_dest  = owner_q;
            end
            ST_REPLY: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_REPLY;
                msg_dest  = pid_q;
                msg_data  = mem_rd;
            end
            default: ;
        endcase
    end

    // Assertions
    AST_EXC_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && st_rd == BLK_EXC) |-> ($countones(sh_rd) == 1 && owner_found)); // R3
    AST_SHR_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && st_rd == BLK_SHR) |-> (sh_rd != '0)); // R4
    AST_UNC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && st_rd == BLK_UNC) |-> (sh_rd == '0)); // R8
    AST_INV_SKIPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_INV) |-> (msg_dest != pid_q)); // R5
    AST_INV_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_INV && $past(msg_valid && msg_kind == MSG_INV))
        |-> (msg_dest > $past(msg_dest))); // R5
    AST_FETCH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind == MSG_FETCH || msg_kind == MSG_FETCH_INV)) |=> !req_ready); // R10
    AST_REPLY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_REPLY) |=> req_ready); // R2
endmodule

// File: tb/test_dir_home.sv
module test_dir_home;
    localparam int NP = 4;
    localparam int NB = 8;
    localparam int DW = 16;
    localparam int PW = 2;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [PW-1:0] req_pid = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          msg_valid;
    logic [2:0]    msg_kind;
    logic [PW-1:0] msg_dest;
    logic [AW-1:0] msg_addr;
    logic [DW-1:0] msg_data;

    dir_home #(.NPROC(NP), .NBLK(NB), .DW(DW)) i_dir_home (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_pid(req_pid), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always #4 clk = ~clk;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    // Reference directory: 0 uncached, 1 shared, 2 exclusive
    int          mst  [NB];
    logic [NP-1:0] msh [NB];
    logic [DW-1:0] mmem [NB];

    int          ek   [8];
    int          edst [8];
    logic [DW-1:0] edat [8];
    string       etag [8];
    int          ne;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int owner_of(input logic [NP-1:0] v);
        int r = 0;
        for (int i = NP - 1; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    task automatic add_exp(input int k, input int d, input logic [DW-1:0] v, input string t);
        ek[ne] = k; edst[ne] = d; edat[ne] = v; etag[ne] = t; ne++;
    endtask

    task automatic run_req(input int k, input int p, input int a,
                           input logic [DW-1:0] d, input logic [DW-1:0] nv,
                           input string ovr);
        int idx = 0;
        bit fetched = 1'b0;
        bit replied = 1'b0;
        int cnt = 0;
        logic [NP-1:0] poh = NP'(1) << p;
        string t;
        ne = 0;
        // Build expectations from the reference model and update it
        case (k)
            0: begin
                if (mst[a] == 0) begin
                    t = "R2"; add_exp(4, p, mmem[a], t); mst[a] = 1; msh[a] = poh;
                end else if (mst[a] == 1) begin
                    t = "R4"; add_exp(4, p, mmem[a], t); msh[a] |= poh;
                end else begin
                    t = "R6"; add_exp(2, owner_of(msh[a]), '0, t);
                    mmem[a] = nv; add_exp(4, p, nv, t); mst[a] = 1; msh[a] |= poh;
                end
            end
            1: begin
                if (mst[a] == 0) begin
                    t = "R3"; add_exp(4, p, mmem[a], t);
                end else if (mst[a] == 1) begin
                    t = "R5";
                    for (int i = 0; i < NP; i++)
                        if (msh[a][i] && i != p) add_exp(1, i, '0, t);
                    add_exp(4, p, mmem[a], t);
                end else begin
                    t = "R7"; add_exp(3, owner_of(msh[a]), '0, t);
                    mmem[a] = nv; add_exp(4, p, nv, t);
                end
                mst[a] = 2; msh[a] = poh;
            end
            2: begin
                if (mst[a] == 2) begin
                    t = "R8"; mmem[a] = d; mst[a] = 0; msh[a] = '0;
                end else t = "R9";
            end
            default: t = "R9";
        endcase
        if (ovr != "") for (int i = 0; i < ne; i++) etag[i] = ovr;

        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(k); req_pid = PW'(p);
        req_addr = AW'(a); req_data = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            if (msg_valid) begin
                if (idx < ne) begin
                    check(msg_kind == 3'(ek[idx]), etag[idx], "kind", msg_kind, ek[idx]);
                    check(msg_dest == PW'(edst[idx]), etag[idx], "dest", msg_dest, edst[idx]);
                    check(msg_addr == AW'(a), "R10", "addr", msg_addr, a);
                    if (ek[idx] == 4)
                        check(msg_data == edat[idx], etag[idx], "data", msg_data, edat[idx]);
                end else begin
                    check(1'b0, t, "extra message", msg_kind, 0);
                end
                if (msg_kind == 3'd2 || msg_kind == 3'd3) begin
                    fetched = 1'b1; cnt = 1 + int'($urandom % 3);
                end
                if (msg_kind == 3'd4) replied = 1'b1;
                idx++;
            end
            if (fetched && !replied)
                check(req_ready == 1'b0, "R10", "ready while waiting", req_ready, 0);
            if (rsp_valid) begin
                rsp_valid = 1'b0;
            end else if (fetched && cnt > 0 && !(msg_valid && (msg_kind == 3'd2 || msg_kind == 3'd3) && cnt == 0)) begin
                if (!(msg_valid && (msg_kind == 3'd2 || msg_kind == 3'd3))) begin
                    cnt--;
                    if (cnt == 0) begin
                        rsp_valid = 1'b1; rsp_data = nv;
                    end
                end
            end
            if (req_ready) break;
            @(negedge clk);
        end
        check(idx == ne, t, "message count", idx, ne);
        check(req_ready == 1'b1, t, "returns ready", req_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int b = 0; b < NB; b++) begin
            mst[b] = 0; msh[b] = '0; mmem[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(msg_valid == 1'b0, "R1", "no message after reset", msg_valid, 0);

        // Directed corner cases
        run_req(0, 1, 5, '0, '0, "R1");
        run_req(1, 0, 1, '0, '0, "");
        run_req(0, 2, 1, '0, 16'hA5A5, "");
        run_req(0, 3, 1, '0, '0, "");
        run_req(1, 2, 1, '0, '0, "");
        run_req(1, 1, 1, '0, 16'h1234, "");
        run_req(2, 1, 1, 16'hBEEF, '0, "");
        run_req(0, 0, 1, '0, '0, "R8");
        run_req(2, 3, 1, 16'hDEAD, '0, "");
        run_req(3, 0, 1, 16'hFFFF, '0, "");
        run_req(0, 2, 1, '0, '0, "R9");
        run_req(1, 3, 6, '0, '0, "");
        run_req(1, 3, 6, '0, 16'h0F0F, "");
        run_req(0, 3, 6, '0, 16'h7777, "");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom % 8);
            int k = (r < 3) ? 0 : (r < 6) ? 1 : (r == 6) ? 2 : 3;
            run_req(k, int'($urandom % NP), int'($urandom % NB),
                    DW'($urandom), DW'($urandom), "");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule